// File: doc/BRIEF.md
# Triple-Level Cell Hard-Read Reference Sequencer

This block drives the hard read of a three-bit-per-cell flash array through a simple comparator handshake. A read starts with a one-cycle start pulse that carries the page to read, the read mode and the choice between two Gray bit labelings. The block works out which of the seven reference levels that read needs. It offers them one at a time, lowest index first. For each offered reference it takes a single response bit that says whether the cell conducts at that reference.

In page mode only the references where the chosen page bit changes between neighbouring charge states are issued. The page bit then follows from how many of those references the cell stays off at. In cell mode all seven references are swept, and the block returns the resolved charge state together with its three labelled bits. Every result comes with a one-cycle valid strobe and the number of references that read used, so that the read latency can be tracked.

Charge states are numbered 0 to 7 from the lowest threshold upward. Reference i lies between state i and state i+1. A cell conducts at reference i exactly when its state is i or lower.

Top module: `flash_ref_seq`

## Requirements
- R1: After reset, `ref_req`, `busy` and `res_valid` are 0.
- R2: References are offered on `ref_req`/`ref_idx` in strictly ascending index order, one per acknowledge. While `ref_ack` is low, `ref_req` stays high and `ref_idx` does not change.
- R3: With `rd_cellwise`=1, all seven references 0..6 are issued. `res_state` is the number of references at which `cell_on` was 0. `res_bits` is that state's label as {MSB,CSB,LSB}.
- R4: With `rd_label_b`=1 (states 0..7 labelled 111,110,100,101,001,000,010,011), a page read issues only these references: MSB {3}, CSB {1,5}, LSB {0,2,4,6}.
- R5: With `rd_label_b`=0 (states 0..7 labelled 111,110,100,000,010,011,001,101), a page read issues only these references: MSB {2,6}, CSB {1,3,5}, LSB {0,4}.
- R6: `res_page_bit` equals the selected page's bit in the label of the cell's charge state. `rd_page` is encoded 0=MSB (label bit 2), 1=CSB (bit 1), 2 or 3=LSB (bit 0). In page mode `res_state` and `res_bits` read 0.
- R7: `res_ref_cnt` equals the number of references issued for that read: 1 to 7, and 7 in cell mode.
- R8: A start pulse while `busy` is 1 is ignored. The running read keeps its page, mode and labeling, and no further read follows.
- R9: `res_valid` is high for exactly one cycle, on the cycle after the final acknowledge. The result outputs hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start | input | 1 | One-cycle read launch, taken only when idle |
| rd_page | input | 2 | Page select: 0 MSB, 1 CSB, 2/3 LSB |
| rd_cellwise | input | 1 | 1: sweep all references and resolve the full cell |
| rd_label_b | input | 1 | Labeling select: 0 first labeling, 1 second labeling |
| ref_req | output | 1 | A reference is being offered to the sense path |
| ref_idx | output | 3 | Index of the offered reference (0..6) |
| ref_ack | input | 1 | Sense path has evaluated the offered reference |
| cell_on | input | 1 | Cell conducts at the offered reference, valid with `ref_ack` |
| busy | output | 1 | A read is in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_page_bit | output | 1 | Resolved bit of the selected page |
| res_state | output | 3 | Resolved charge state (cell mode), else 0 |
| res_bits | output | 3 | Resolved {MSB,CSB,LSB} (cell mode), else 0 |
| res_ref_cnt | output | 3 | References used by this read |

## Verification
The assertions assume three things about the inputs. `ref_ack` is raised only while `ref_req` is high. `cell_on` is meaningful in the acknowledge cycle. The responses come from a real threshold, so once a cell conducts at one reference it conducts at every higher one. The bench keeps to these assumptions with a cell model that holds one fixed charge state for each read. That model answers each offered reference with "state is at or below the index". The bench acknowledges only after it has seen a request at the falling edge, sometimes after several idle cycles, and it pulses the start input for a single cycle. A start during a busy read is the one deliberate exception, and the bench uses it to show that such a start has no effect.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  localparam int CELL_BITS  = 3;
  localparam int NUM_STATES = 1 << CELL_BITS;
  localparam int NUM_REFS   = NUM_STATES - 1;
  localparam int STATE_W    = CELL_BITS;
  localparam int REF_W      = $clog2(NUM_REFS);
  localparam int CNT_W      = $clog2(NUM_REFS + 1);
  localparam int POS_W      = $clog2(CELL_BITS);

  typedef enum logic [1:0] {
    PAGE_MSB = 2'd0,
    PAGE_CSB = 2'd1,
    PAGE_LSB = 2'd2,
    PAGE_ALT = 2'd3
  } page_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ISSUE = 1'b1
  } seq_e;

  // Gray label {MSB,CSB,LSB} of a charge state under either labeling
  function automatic logic [CELL_BITS-1:0] state_label(input logic lab_b,
                                                       input logic [STATE_W-1:0] st);
    logic [CELL_BITS-1:0] v;
    if (!lab_b) begin
      case (st)
        3'd0:    v = 3'b111;
        3'd1:    v = 3'b110;
        3'd2:    v = 3'b100;
        3'd3:    v = 3'b000;
        3'd4:    v = 3'b010;
        3'd5:    v = 3'b011;
        3'd6:    v = 3'b001;
        default: v = 3'b101;
      endcase
    end else begin
      case (st)
        3'd0:    v = 3'b111;
        3'd1:    v = 3'b110;
        3'd2:    v = 3'b100;
        3'd3:    v = 3'b101;
        3'd4:    v = 3'b001;
        3'd5:    v = 3'b000;
        3'd6:    v = 3'b010;
        default: v = 3'b011;
      endcase
    end
    return v;
  endfunction

  function automatic logic pick_bit(input logic [CELL_BITS-1:0] lbl,
                                    input logic [POS_W-1:0] pos);
    logic b;
    case (pos)
      2'd2:    b = lbl[2];
      2'd1:    b = lbl[1];
      default: b = lbl[0];
    endcase
    return b;
  endfunction

  // Page select to label bit position (MSB is the top bit)
  function automatic logic [POS_W-1:0] page_to_pos(input logic [1:0] pg);
    logic [POS_W-1:0] p;
    case (pg)
      PAGE_MSB: p = 2'd2;
      PAGE_CSB: p = 2'd1;
      default:  p = 2'd0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/frs_mask_gen.sv
module frs_mask_gen
  import flash_rd_pkg::*;
(
  input  logic                lab_b,
  input  logic [POS_W-1:0]    page_pos,
  input  logic                cell_mode,
  output logic [NUM_REFS-1:0] need_mask
);

  // A reference is needed where the page bit flips across it
  for (genvar gi = 0; gi < NUM_REFS; gi++) begin : g_ref
    logic [CELL_BITS-1:0] lo_lbl;
    logic [CELL_BITS-1:0] hi_lbl;
    assign lo_lbl = state_label(lab_b, STATE_W'(gi));
    assign hi_lbl = state_label(lab_b, STATE_W'(gi + 1));
    assign need_mask[gi] = cell_mode |
                           (pick_bit(lo_lbl, page_pos) ^ pick_bit(hi_lbl, page_pos));
  end

endmodule

// File: rtl/frs_lowest_pick.sv
module frs_lowest_pick #(
  parameter int WIDTH = 7
) (
  input  logic [WIDTH-1:0]         pend,
  output logic [$clog2(WIDTH)-1:0] idx
);

  localparam int IDX_W = $clog2(WIDTH);

  // Scan downward so the lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/frs_resolve.sv
module frs_resolve
  import flash_rd_pkg::*;
(
  input  logic                 lab_b,
  input  logic [POS_W-1:0]     page_pos,
  input  logic                 cell_mode,
  input  logic [STATE_W-1:0]   off_cnt,
  output logic                 page_bit,
  output logic [STATE_W-1:0]   state,
  output logic [CELL_BITS-1:0] bits
);

  logic [CELL_BITS-1:0] base_lbl;
  logic [CELL_BITS-1:0] cell_lbl;

  assign base_lbl = state_label(lab_b, '0);
  assign cell_lbl = state_label(lab_b, off_cnt);

  always_comb begin
    if (cell_mode) begin
      page_bit = pick_bit(cell_lbl, page_pos);
      state    = off_cnt;
      bits     = cell_lbl;
    end else begin
      // every crossed boundary of this page flips its bit once
      page_bit = pick_bit(base_lbl, page_pos) ^ off_cnt[0];
      state    = '0;
      bits     = '0;
    end
  end

endmodule

// File: rtl/flash_ref_seq.sv
module flash_ref_seq
  import flash_rd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_start,
  input  logic [1:0]           rd_page,
  input  logic                 rd_cellwise,
  input  logic                 rd_label_b,
  output logic                 ref_req,
  output logic [REF_W-1:0]     ref_idx,
  input  logic                 ref_ack,
  input  logic                 cell_on,
  output logic                 busy,
  output logic                 res_valid,
  output logic                 res_page_bit,
  output logic [STATE_W-1:0]   res_state,
  output logic [CELL_BITS-1:0] res_bits,
  output logic [CNT_W-1:0]     res_ref_cnt
);

  seq_e                 st_q, st_d;
  logic [NUM_REFS-1:0]  pend_q, pend_d;
  logic [CNT_W-1:0]     off_q, off_d;
  logic [CNT_W-1:0]     used_q, used_d;
  logic                 lab_q, cell_q;
  logic [POS_W-1:0]     pos_q;
  logic                 cfg_en;
  logic                 fin;

  logic [NUM_REFS-1:0]  start_mask;
  logic [NUM_REFS-1:0]  pick_onehot;
  logic [REF_W-1:0]     pick_idx;

  logic                 rv_page_bit;
  logic [STATE_W-1:0]   rv_state;
  logic [CELL_BITS-1:0] rv_bits;

  frs_mask_gen u_mask (
    .lab_b     (rd_label_b),
    .page_pos  (page_to_pos(rd_page)),
    .cell_mode (rd_cellwise),
    .need_mask (start_mask)
  );

  frs_lowest_pick #(.WIDTH(NUM_REFS)) u_pick (
    .pend (pend_q),
    .idx  (pick_idx)
  );

  frs_resolve u_res (
    .lab_b     (lab_q),
    .page_pos  (pos_q),
    .cell_mode (cell_q),
    .off_cnt   (STATE_W'(off_d)),
    .page_bit  (rv_page_bit),
    .state     (rv_state),
    .bits      (rv_bits)
  );

  assign pick_onehot = NUM_REFS'(1) << pick_idx;
  assign ref_req     = (st_q == SEQ_ISSUE);
  assign ref_idx     = pick_idx;
  assign busy        = (st_q != SEQ_IDLE);

  // next-state logic
  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    off_d  = off_q;
    used_d = used_q;
    cfg_en = 1'b0;
    fin    = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (rd_start) begin
          st_d   = SEQ_ISSUE;
          pend_d = start_mask;
          off_d  = '0;
          used_d = '0;
          cfg_en = 1'b1;
        end
      end
      SEQ_ISSUE: begin
        if (ref_ack) begin
          pend_d = pend_q & ~pick_onehot;
          off_d  = off_q + {{(CNT_W-1){1'b0}}, ~cell_on};
          used_d = used_q + CNT_W'(1);
          if (pend_d == '0) begin
            fin  = 1'b1;
            st_d = SEQ_IDLE;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      pend_q <= '0;
      off_q  <= '0;
      used_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      off_q  <= off_d;
      used_q <= used_d;
    end
  end

  // read configuration, captured at launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lab_q  <= 1'b0;
      cell_q <= 1'b0;
      pos_q  <= '0;
    end else if (cfg_en) begin
      lab_q  <= rd_label_b;
      cell_q <= rd_cellwise;
      pos_q  <= page_to_pos(rd_page);
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_page_bit <= 1'b0;
      res_state    <= '0;
      res_bits     <= '0;
      res_ref_cnt  <= '0;
    end else begin
      res_valid <= fin;
      if (fin) begin
        res_page_bit <= rv_page_bit;
        res_state    <= rv_state;
        res_bits     <= rv_bits;
        res_ref_cnt  <= used_d;
      end
    end
  end

  // ---------------- assertions ----------------
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> (ref_req && $stable(ref_idx)));

  p_idx_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_ack) |=> (!ref_req || (ref_idx > $past(ref_idx))));

  p_cell_seven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cell_q) |-> (res_ref_cnt == CNT_W'(NUM_REFS)));

  p_cnt_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_ref_cnt != '0));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_start) |=> ($stable(lab_q) && $stable(pos_q) && $stable(cell_q)));

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

endmodule

// File: tb/flash_ref_seq_tb.sv
`timescale 1ns/1ps
module flash_ref_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_start, rd_cellwise, rd_label_b, ref_ack, cell_on;
  logic [1:0] rd_page;
  logic       ref_req, busy, res_valid, res_page_bit;
  logic [2:0] ref_idx, res_state, res_bits, res_ref_cnt;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // captured by do_read
  logic [6:0] got_mask;
  int         issued;
  bit         asc_ok, hold_ok, got_valid, valid_after, held_ok;
  logic       cap_bit;
  logic [2:0] cap_state, cap_bits, cap_cnt;

  always #4 clk = ~clk;

  flash_ref_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_page(rd_page),
    .rd_cellwise(rd_cellwise), .rd_label_b(rd_label_b), .ref_req(ref_req),
    .ref_idx(ref_idx), .ref_ack(ref_ack), .cell_on(cell_on), .busy(busy),
    .res_valid(res_valid), .res_page_bit(res_page_bit), .res_state(res_state),
    .res_bits(res_bits), .res_ref_cnt(res_ref_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] lbl(input logic lb, input int st);
    logic [2:0] a [8] = '{3'b111, 3'b110, 3'b100, 3'b000, 3'b010, 3'b011, 3'b001, 3'b101};
    logic [2:0] b [8] = '{3'b111, 3'b110, 3'b100, 3'b101, 3'b001, 3'b000, 3'b010, 3'b011};
    return lb ? b[st] : a[st];
  endfunction

  function automatic int bitpos(input logic [1:0] pg);
    return (pg == 2'd0) ? 2 : (pg == 2'd1) ? 1 : 0;
  endfunction

  // reference sets listed in R4 and R5
  function automatic logic [6:0] exp_mask(input logic lb, input logic [1:0] pg);
    int p = bitpos(pg);
    if (lb) return (p == 2) ? 7'b0001000 : (p == 1) ? 7'b0100010 : 7'b1010101;
    else    return (p == 2) ? 7'b1000100 : (p == 1) ? 7'b0101010 : 7'b0010001;
  endfunction

  task automatic do_read(input logic [1:0] pg, input logic cm, input logic lb,
                         input int ts, input int gap, input bit poke);
    int last = -1;
    got_mask = '0; issued = 0; asc_ok = 1; hold_ok = 1; got_valid = 0;
    rd_page = pg; rd_cellwise = cm; rd_label_b = lb; rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    for (int cyc = 0; cyc < 60; cyc++) begin
      if (res_valid) begin
        got_valid = 1;
        break;
      end
      if (ref_req) begin
        int idx;
        idx = int'(ref_idx);
        if (idx <= last) asc_ok = 0;
        last = idx;
        got_mask[idx] = 1'b1;
        issued++;
        for (int g = 0; g < gap; g++) begin
          if (poke && g == 0) begin
            rd_start = 1'b1; rd_page = pg + 2'd1; rd_cellwise = ~cm; rd_label_b = ~lb;
          end
          @(negedge clk);
          rd_start = 1'b0;
          if (!ref_req || int'(ref_idx) != idx) hold_ok = 0;
        end
        ref_ack = 1'b1;
        cell_on = (ts <= idx);
        @(negedge clk);
        ref_ack = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    cap_bit = res_page_bit; cap_state = res_state; cap_bits = res_bits; cap_cnt = res_ref_cnt;
    @(negedge clk);
    valid_after = res_valid;
    held_ok = (res_page_bit == cap_bit) && (res_state == cap_state) &&
              (res_bits == cap_bits) && (res_ref_cnt == cap_cnt);
  endtask

  task automatic t_reset;
    chk(ref_req == 1'b0, "R1 ref_req", int'(ref_req), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
  endtask

  task automatic t_cell_sweep;
    for (int lb = 0; lb < 2; lb++) begin
      for (int ts = 0; ts < 8; ts++) begin
        logic [2:0] e;
        e = lbl(lb[0], ts);
        do_read(2'd1, 1'b1, lb[0], ts, 0, 0);
        chk(got_valid, "R9 result strobe", int'(got_valid), 1);
        chk(got_mask == 7'h7F && issued == 7, "R3 refs swept", int'(got_mask), 127);
        chk(asc_ok, "R2 ascending", int'(asc_ok), 1);
        chk(cap_state == 3'(ts), "R3 state", int'(cap_state), ts);
        chk(cap_bits == e, "R3 bits", int'(cap_bits), int'(e));
        chk(cap_bit == e[1], "R6 page bit cell mode", int'(cap_bit), int'(e[1]));
        chk(cap_cnt == 3'd7, "R7 count cell", int'(cap_cnt), 7);
        chk(!valid_after && held_ok, "R9 pulse and hold", int'(valid_after), 0);
      end
    end
  endtask

  task automatic t_page_reads;
    for (int lb = 0; lb < 2; lb++) begin
      for (int pg = 0; pg < 4; pg++) begin
        for (int ts = 0; ts < 8; ts++) begin
          logic [6:0] m;
          logic       eb;
          m  = exp_mask(lb[0], 2'(pg));
          eb = lbl(lb[0], ts)[bitpos(2'(pg))];
          do_read(2'(pg), 1'b0, lb[0], ts, 0, 0);
          if (lb == 1) chk(got_mask == m, "R4 reference set", int'(got_mask), int'(m));
          else         chk(got_mask == m, "R5 reference set", int'(got_mask), int'(m));
          chk(asc_ok, "R2 ascending", int'(asc_ok), 1);
          chk(got_valid && cap_bit == eb, "R6 page bit", int'(cap_bit), int'(eb));
          chk(cap_state == 3'd0 && cap_bits == 3'd0, "R6 page-mode state zero",
              int'(cap_state), 0);
          chk(int'(cap_cnt) == $countones(m) && issued == $countones(m), "R7 count",
              int'(cap_cnt), $countones(m));
        end
      end
    end
  endtask

  task automatic t_hold_gap;
    do_read(2'd1, 1'b0, 1'b0, 4, 3, 0);
    chk(hold_ok, "R2 request held without ack", int'(hold_ok), 1);
    chk(cap_bit == lbl(1'b0, 4)[1], "R6 bit after slow acks", int'(cap_bit),
        int'(lbl(1'b0, 4)[1]));
    chk(cap_cnt == 3'd3, "R7 count after slow acks", int'(cap_cnt), 3);
  endtask

  task automatic t_busy_start;
    bit extra;
    do_read(2'd2, 1'b0, 1'b1, 3, 2, 1);
    chk(got_mask == 7'b1010101, "R8 config kept", int'(got_mask), 85);
    chk(cap_bit == lbl(1'b1, 3)[0], "R8 bit kept", int'(cap_bit), int'(lbl(1'b1, 3)[0]));
    chk(cap_state == 3'd0 && cap_cnt == 3'd4, "R8 mode kept", int'(cap_cnt), 4);
    extra = 0;
    for (int k = 0; k < 6; k++) begin
      if (ref_req || busy || res_valid) extra = 1;
      @(negedge clk);
    end
    chk(!extra, "R8 no second read", int'(extra), 0);
  endtask

  initial begin
    rst_n = 1'b0; rd_start = 1'b0; rd_page = 2'd0; rd_cellwise = 1'b0;
    rd_label_b = 1'b0; ref_ack = 1'b0; cell_on = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cell_sweep();
    t_page_reads();
    t_hold_gap();
    t_busy_start();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule